// File: doc/BRIEF.md
# Landing Gear Sequencing Controller

This block is a clocked Moore state machine that sequences a hydraulic landing-gear mechanism. It reads a pilot lever, a weight-on-ground sensor and two end-of-travel sensors (gear fully up, gear fully down). From these it drives a hydraulic pump enable, a valve direction select, a red "gear moving" lamp and a green "gear down" lamp. All four outputs are decoded only from the registered state, so no input reaches an output without passing through a clock edge.

Retraction is locked out while the aircraft is on the ground. It also requires a continuous airborne interval, measured by an internal timer, before the gear may be raised. The timer length is the parameter `DELAY_CYCLES`, which defaults to two seconds at 125 MHz and can be made short for simulation. If the lever is reversed while the gear is travelling, the motion turns around at once.

The six states are Ground-Hold (waiting for takeoff), Air-Wait (waiting for the airborne timer), Raising, Stowed (gear up), Lowering and Deployed (gear down). The transitions are:
- Ground-Hold to Air-Wait on lift-off.
- Air-Wait back to Ground-Hold on touchdown.
- Air-Wait to Raising once the timer has expired with the lever up.
- Raising to Stowed on the up sensor, and Raising to Lowering on a lever reversal.
- Stowed to Lowering on the lever.
- Lowering to Deployed on the down sensor, and Lowering to Raising on a lever reversal.
- Deployed to Air-Wait or to Ground-Hold on lever up, depending on the ground sensor.

Top module: `gear_seq_ctrl`

## Requirements
- R1: A synchronous reset (`rst`=1 at a clock edge) puts the block in Ground-Hold. Its outputs are then pump 0, valve 0, red 0, green 1.
- R2: The airborne timer is cleared in every state except Air-Wait. In Air-Wait it advances by one per clock until it reaches `DELAY_CYCLES`, and it then holds that value.
- R3: Ground-Hold moves to Air-Wait on the first edge with `on_ground`=0. Air-Wait returns to Ground-Hold on any edge with `on_ground`=1. Raising is entered only from Air-Wait, and only after the timer has expired and with `lever_down`=0. Raising is therefore first seen `DELAY_CYCLES`+1 edges after Air-Wait is entered.
- R4: While in Ground-Hold or Air-Wait with `lever_down`=1 (lever encoding: 1 = gear down, 0 = gear up), the gear is never raised, even after the timer has expired.
- R5: In Raising, `lever_down`=1 moves to Lowering, and this takes priority over the up sensor. Otherwise `gear_up_sns`=1 moves to Stowed, and if neither input is active the block stays in Raising.
- R6: In Stowed, `lever_down`=1 moves to Lowering. The sensors have no effect in this state.
- R7: In Lowering, `lever_down`=0 moves to Raising, and this takes priority over the down sensor. Otherwise `gear_down_sns`=1 moves to Deployed.
- R8: In Deployed, `lever_down`=0 moves to Air-Wait if `on_ground`=0, or to Ground-Hold if `on_ground`=1. Deployed never moves straight to Raising.
- R9: The output encoding by state is as follows:
  - Raising: pump 1, valve 0, red 1, green 0.
  - Lowering: pump 1, valve 1, red 1, green 0. Valve encoding is 1 = lowering, 0 = raising.
  - Stowed: all outputs 0.
  - Ground-Hold, Air-Wait and Deployed: green 1, all other outputs 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| lever_down | input | 1 | Pilot lever, 1 = gear down, 0 = gear up |
| on_ground | input | 1 | Weight-on-ground sensor, active high |
| gear_up_sns | input | 1 | Gear fully retracted sensor, active high |
| gear_down_sns | input | 1 | Gear fully extended sensor, active high |
| valve_lower | output | 1 | Valve direction, 1 = lowering, 0 = raising or idle |
| pump_on | output | 1 | Hydraulic pump enable |
| lamp_moving | output | 1 | Red lamp, gear in motion |
| lamp_down | output | 1 | Green lamp, gear down and locked |

## Verification
The main sequence is driven through a full flight: lift-off, a timer wait with the lever still down, retraction, extension, and touchdown. It is run once from Air-Wait entered from Ground-Hold and once from Air-Wait entered from Deployed. The Raising lamp pattern must appear on exactly the (`DELAY_CYCLES`+1)-th edge, which separates a timer that is cleared correctly from one that keeps a stale count. Patterns where both the lever and an end sensor are active in the same cycle show whether the lever has priority over the sensor. A sensor asserted in Stowed shows that sensors are ignored there. A touchdown partway through the wait, followed by a second lift-off, shows that the timer restarts rather than resumes.

// File: rtl/gear_pkg.sv
package gear_pkg;

    typedef enum logic [2:0] {
        ST_GROUND_HOLD = 3'd0,
        ST_AIR_WAIT    = 3'd1,
        ST_RAISING     = 3'd2,
        ST_STOWED      = 3'd3,
        ST_LOWERING    = 3'd4,
        ST_DEPLOYED    = 3'd5
    } gear_state_t;

    typedef struct packed {
        logic pump_on;
        logic valve_lower;
        logic lamp_moving;
        logic lamp_down;
    } gear_drive_t;

endpackage

// File: rtl/gear_air_timer.sv
module gear_air_timer #(
    parameter int DELAY_CYCLES = 250_000_000
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic done
);
    localparam int CW = $clog2(DELAY_CYCLES + 1);
    localparam logic [CW-1:0] LIMIT = CW'(DELAY_CYCLES);

    logic [CW-1:0] count_q;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            count_q <= '0;
        end else if (count_q != LIMIT) begin
            count_q <= count_q + 1'b1;
        end
    end

    assign done = (count_q == LIMIT);

    // R2: leaving the counting state clears the count
    assert_timer_cleared_R2: assert property (@(posedge clk) disable iff (rst)
        !run |=> (count_q == '0));

    // R2: once expired while counting, the timer stays expired
    assert_timer_saturates_R2: assert property (@(posedge clk) disable iff (rst)
        (run && done) |=> done);

endmodule

// File: rtl/gear_next_state.sv
module gear_next_state
    import gear_pkg::*;
(
    input  gear_state_t cur,
    input  logic        lever_down,
    input  logic        on_ground,
    input  logic        gear_up_sns,
    input  logic        gear_down_sns,
    input  logic        timer_done,
    output gear_state_t nxt
);
    always_comb begin
        nxt = cur;
        unique case (cur)
            ST_GROUND_HOLD: begin
                if (!on_ground) nxt = ST_AIR_WAIT;
            end
            ST_AIR_WAIT: begin
                if (on_ground)                     nxt = ST_GROUND_HOLD;
                else if (timer_done && !lever_down) nxt = ST_RAISING;
            end
            ST_RAISING: begin
                if (lever_down)       nxt = ST_LOWERING;
                else if (gear_up_sns) nxt = ST_STOWED;
            end
            ST_STOWED: begin
                if (lever_down) nxt = ST_LOWERING;
            end
            ST_LOWERING: begin
                if (!lever_down)        nxt = ST_RAISING;
                else if (gear_down_sns) nxt = ST_DEPLOYED;
            end
            ST_DEPLOYED: begin
                if (!lever_down) nxt = on_ground ? ST_GROUND_HOLD : ST_AIR_WAIT;
            end
            default: nxt = ST_GROUND_HOLD;
        endcase
    end
endmodule

// File: rtl/gear_output_decode.sv
module gear_output_decode
    import gear_pkg::*;
(
    input  gear_state_t cur,
    output gear_drive_t drv
);
    always_comb begin
        drv = '0;
        unique case (cur)
            ST_GROUND_HOLD: drv.lamp_down = 1'b1;
            ST_AIR_WAIT:    drv.lamp_down = 1'b1;
            ST_RAISING: begin
                drv.pump_on     = 1'b1;
                drv.lamp_moving = 1'b1;
            end
            ST_STOWED:      drv = '0;
            ST_LOWERING: begin
                drv.pump_on     = 1'b1;
                drv.valve_lower = 1'b1;
                drv.lamp_moving = 1'b1;
            end
            ST_DEPLOYED:    drv.lamp_down = 1'b1;
            default:        drv = '0;
        endcase
    end

    // R9: the pump and the red lamp are never on together with the green lamp
    always_comb begin
        assert_lamps_exclusive_R9: assert (!(drv.pump_on && drv.lamp_down));
    end
endmodule

// File: rtl/gear_seq_ctrl.sv
module gear_seq_ctrl
    import gear_pkg::*;
#(
    parameter int DELAY_CYCLES = 250_000_000
) (
    input  logic clk,
    input  logic rst,
    input  logic lever_down,
    input  logic on_ground,
    input  logic gear_up_sns,
    input  logic gear_down_sns,
    output logic valve_lower,
    output logic pump_on,
    output logic lamp_moving,
    output logic lamp_down
);
    gear_state_t state_q;
    gear_state_t state_d;
    gear_drive_t drive;
    logic        timer_done;

    gear_air_timer #(.DELAY_CYCLES(DELAY_CYCLES)) u_timer (
        .clk  (clk),
        .rst  (rst),
        .run  (state_q == ST_AIR_WAIT),
        .done (timer_done)
    );

    gear_next_state u_next (
        .cur           (state_q),
        .lever_down    (lever_down),
        .on_ground     (on_ground),
        .gear_up_sns   (gear_up_sns),
        .gear_down_sns (gear_down_sns),
        .timer_done    (timer_done),
        .nxt           (state_d)
    );

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_GROUND_HOLD;
        else     state_q <= state_d;
    end

    gear_output_decode u_out (
        .cur (state_q),
        .drv (drive)
    );

    assign pump_on     = drive.pump_on;
    assign valve_lower = drive.valve_lower;
    assign lamp_moving = drive.lamp_moving;
    assign lamp_down   = drive.lamp_down;

    // R1: reset lands in Ground-Hold
    assert_reset_hold_R1: assert property (@(posedge clk)
        rst |=> (state_q == ST_GROUND_HOLD));

    // R3: no retraction before the airborne timer has expired
    assert_no_early_raise_R3: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_AIR_WAIT && !timer_done) |=> (state_q != ST_RAISING));

    // R4: lever down in a waiting state never raises the gear
    assert_lever_down_blocks_R4: assert property (@(posedge clk) disable iff (rst)
        ((state_q == ST_AIR_WAIT || state_q == ST_GROUND_HOLD) && lever_down)
        |=> (state_q != ST_RAISING));

    // R5: lever reversal beats the up sensor
    assert_raise_reversal_R5: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_RAISING && lever_down) |=> (state_q == ST_LOWERING));

    // R7: lever reversal beats the down sensor
    assert_lower_reversal_R7: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_LOWERING && !lever_down) |=> (state_q == ST_RAISING));

    // R8: Deployed never goes straight to Raising
    assert_deployed_no_raise_R8: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_DEPLOYED) |=> (state_q != ST_RAISING));

    // R6: sensors alone never move the gear out of Stowed
    assert_stowed_holds_R6: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_STOWED && !lever_down) |=> (state_q == ST_STOWED));

endmodule

// File: tb/test_gear_seq_ctrl.sv
module test_gear_seq_ctrl;

    localparam int DLY = 5;

    localparam logic [3:0] O_IDLE  = 4'b0001; // {pump, valve, red, green}
    localparam logic [3:0] O_RAISE = 4'b1010;
    localparam logic [3:0] O_LOWER = 4'b1110;
    localparam logic [3:0] O_UP    = 4'b0000;

    // {req[3:0], rst, lever_down, on_ground, up_sns, down_sns, expected[3:0]}
    localparam int NV = 39;
    localparam logic [12:0] VEC [NV] = '{
        {4'd1, 5'b11100, O_IDLE},  // 0  R1 reset
        {4'd1, 5'b01100, O_IDLE},  // 1  R1 held on ground
        {4'd3, 5'b01000, O_IDLE},  // 2  R3 lift-off -> Air-Wait
        {4'd2, 5'b01000, O_IDLE},  // 3  R2 counting
        {4'd2, 5'b01000, O_IDLE},  // 4
        {4'd2, 5'b01000, O_IDLE},  // 5
        {4'd2, 5'b01000, O_IDLE},  // 6
        {4'd2, 5'b01000, O_IDLE},  // 7  expired
        {4'd4, 5'b01000, O_IDLE},  // 8  R4 lever down blocks
        {4'd3, 5'b00000, O_RAISE}, // 9  R3 raise
        {4'd5, 5'b00000, O_RAISE}, // 10 R5 stays raising
        {4'd5, 5'b00010, O_UP},    // 11 R5 up sensor
        {4'd6, 5'b00011, O_UP},    // 12 R6 sensors ignored
        {4'd6, 5'b01010, O_LOWER}, // 13 R6 lever down
        {4'd7, 5'b00000, O_RAISE}, // 14 R7 reversal
        {4'd5, 5'b01010, O_LOWER}, // 15 R5 lever beats up sensor
        {4'd7, 5'b01001, O_IDLE},  // 16 R7 down sensor -> Deployed
        {4'd9, 5'b01001, O_IDLE},  // 17 R9 deployed green
        {4'd8, 5'b00001, O_IDLE},  // 18 R8 airborne -> Air-Wait
        {4'd8, 5'b00000, O_IDLE},  // 19 R8 not raising directly
        {4'd2, 5'b00000, O_IDLE},  // 20 R2 fresh count
        {4'd2, 5'b00000, O_IDLE},  // 21
        {4'd2, 5'b00000, O_IDLE},  // 22
        {4'd2, 5'b00000, O_IDLE},  // 23 expired
        {4'd3, 5'b00000, O_RAISE}, // 24 R3 raise at DLY+1
        {4'd9, 5'b01000, O_LOWER}, // 25 R9 lowering pattern
        {4'd7, 5'b01101, O_IDLE},  // 26 R7 -> Deployed
        {4'd8, 5'b00101, O_IDLE},  // 27 R8 on ground -> Ground-Hold
        {4'd8, 5'b00100, O_IDLE},  // 28
        {4'd3, 5'b00000, O_IDLE},  // 29 R3 Air-Wait
        {4'd3, 5'b00000, O_IDLE},  // 30
        {4'd3, 5'b00000, O_IDLE},  // 31
        {4'd3, 5'b00000, O_IDLE},  // 32
        {4'd3, 5'b00000, O_IDLE},  // 33
        {4'd3, 5'b00000, O_IDLE},  // 34 expired
        {4'd3, 5'b00000, O_RAISE}, // 35 R3 raise
        {4'd5, 5'b00010, O_UP},    // 36 R5 stowed
        {4'd1, 5'b10010, O_IDLE},  // 37 R1 reset from stowed
        {4'd3, 5'b00000, O_IDLE}   // 38 R3 Air-Wait after reset
    };

    logic clk = 1'b0;
    logic rst, lever_down, on_ground, gear_up_sns, gear_down_sns;
    logic valve_lower, pump_on, lamp_moving, lamp_down;
    int   n_checks = 0;
    int   n_fail   = 0;
    bit   finished = 1'b0;

    always #4 clk = ~clk;

    gear_seq_ctrl #(.DELAY_CYCLES(DLY)) i_gear_seq_ctrl (
        .clk           (clk),
        .rst           (rst),
        .lever_down    (lever_down),
        .on_ground     (on_ground),
        .gear_up_sns   (gear_up_sns),
        .gear_down_sns (gear_down_sns),
        .valve_lower   (valve_lower),
        .pump_on       (pump_on),
        .lamp_moving   (lamp_moving),
        .lamp_down     (lamp_down)
    );

    task automatic check(input int req, input logic [3:0] exp, input string tag);
        logic [3:0] got;
        got = {pump_on, valve_lower, lamp_moving, lamp_down};
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL R%0d %s: got %b expected %b", req, tag, got, exp);
        end
    endtask

    task automatic step(input logic r, input logic lv, input logic gd,
                        input logic us, input logic ds,
                        input logic [3:0] exp, input int req, input string tag);
        rst = r; lever_down = lv; on_ground = gd;
        gear_up_sns = us; gear_down_sns = ds;
        @(negedge clk);
        check(req, exp, tag);
    endtask

    initial begin
        #(8 * 20000);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < NV; i++) begin
            step(VEC[i][8], VEC[i][7], VEC[i][6], VEC[i][5], VEC[i][4],
                 VEC[i][3:0], int'(VEC[i][12:9]), $sformatf("vector %0d", i));
        end

        // R3 touchdown during the wait restarts the timer (now in Air-Wait, count 0)
        for (int k = 1; k <= 3; k++) step(0, 0, 0, 0, 0, O_IDLE, 3, "partial wait");
        step(0, 0, 1, 0, 0, O_IDLE, 3, "touchdown abort");
        step(0, 0, 0, 0, 0, O_IDLE, 3, "second lift-off");
        for (int k = 1; k <= DLY; k++) step(0, 0, 0, 0, 0, O_IDLE, 2, "restarted count");
        step(0, 0, 0, 0, 0, O_RAISE, 3, "raise after full restart");

        // R7 lever up during lowering turns around even with down sensor set
        step(0, 1, 0, 0, 0, O_LOWER, 7, "lower");
        step(0, 0, 0, 0, 1, O_RAISE, 7, "lever beats down sensor");

        // R1 reset while moving
        step(1, 0, 1, 0, 0, O_IDLE, 1, "reset while raising");
        step(0, 0, 1, 0, 0, O_IDLE, 1, "ground hold after reset");

        finished = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

endmodule